// File: doc/BRIEF.md
# Point-Plot Display Cycle Sequencer

This block runs the timing of one spot-plotting cycle for a random-position CRT display that a host computer drives. The host first sends a clear pulse. The block turns it into two one-cycle clear strobes and empties the coordinate and intensity registers. The host then sends a load pulse. The block captures the horizontal word, the vertical word and the brightness word, and starts a timed sequence with three steps. First comes a settling window, while the beam deflection moves to its new position. Next comes an unblank window, while the spot is lit. Last, a single-cycle completion pulse goes back to the host.

Both windows are counted in clock cycles. By default their lengths are derived from the clock frequency and from settle and unblank times given in microseconds (35 µs and 10 µs). The two clear groups are uneven. The horizontal group empties the whole horizontal register and also the lowest bits of the vertical register. The vertical group empties the rest of the vertical register and the brightness register.

The brightness register stores its top bit inverted. As a result, a cleared register reads back as the level just above the middle of the range.

Top module: `pp_cycle_seq`

## Requirements
- R1: One cycle after `clr_i` is high, `clr_h_o` and `clr_v_o` are both high, and each stays high for exactly one cycle.
- R2: A clear empties `hbuf_o` and the two least-significant bits of `vbuf_o` (horizontal clear group). The new values are visible one cycle after `clr_i`.
- R3: A clear empties the upper bits of `vbuf_o` and the brightness register (vertical clear group). After a clear, `ilevel_o` reads 4 (binary 100), because the register holds its top bit inverted.
- R4: A `ld_i` pulse accepted while idle makes `ld_o` high for one cycle, starting the next cycle. From that same cycle, `hbuf_o`, `vbuf_o` and `ilevel_o` show the words that were present with the pulse.
- R5: `settle_o` is high for exactly SETTLE_CYC cycles, starting the cycle after an accepted load. `unblank_o` stays low during that window.
- R6: `unblank_o` is high for exactly UNBLANK_CYC cycles, starting the cycle after the last settle cycle.
- R7: `done_o` is high for exactly one cycle, directly after the last unblank cycle. `busy_o` is high from the first settle cycle through the last unblank cycle, and low in the done cycle.
- R8: A `ld_i` pulse that arrives while `busy_o` is high is ignored. It produces no `ld_o`, leaves the registers unchanged and does not shift the timing.
- R9: A clear during a busy cycle empties the registers (R2, R3) without changing the settle, unblank or done timing.
- R10: When `clr_i` and `ld_i` arrive together while idle, the clear strobes are still issued, and the registers show the loaded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear request pulse from host |
| ld_i | input | 1 | Load request pulse from host |
| hword_i | input | HW | Horizontal coordinate word |
| vword_i | input | VW | Vertical coordinate word |
| ilevel_i | input | IW | Requested brightness level |
| clr_h_o | output | 1 | Horizontal clear group strobe |
| clr_v_o | output | 1 | Vertical clear group strobe |
| ld_o | output | 1 | Register load strobe |
| settle_o | output | 1 | Deflection settling window |
| unblank_o | output | 1 | Spot lit window |
| done_o | output | 1 | Completion pulse to host |
| busy_o | output | 1 | Cycle in progress |
| hbuf_o | output | HW | Horizontal register |
| vbuf_o | output | VW | Vertical register |
| ilevel_o | output | IW | Brightness level held |

## Verification
The assertions take for granted that `clr_i` and `ld_i` are synchronous to the clock and follow the host's clear-then-load habit. They make no assumption about how far apart the two pulses are, so loads while busy and clears in the middle of a cycle are both legal. The stimulus changes inputs only on the falling edge and holds each request for exactly one cycle. It places the extra load and the extra clear inside the busy window at several different offsets, and it never places a request in the done cycle unless that case is the one under test.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETTLE  = 2'd1,
      PH_UNBLANK = 2'd2
   } phase_e;

   function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
      return (hz / 1000) * us / 1000;
   endfunction
endpackage

// File: rtl/pp_strobe_gen.sv
module pp_strobe_gen (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic ld_i,
   input  logic busy_i,
   output logic ld_acc_o,
   output logic clr_h_o,
   output logic clr_v_o,
   output logic ld_o
);
   assign ld_acc_o = ld_i & ~busy_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         clr_h_o <= 1'b0;
         clr_v_o <= 1'b0;
         ld_o    <= 1'b0;
      end else begin
         clr_h_o <= clr_i;
         clr_v_o <= clr_i;
         ld_o    <= ld_acc_o;
      end
   end

   AST_LOAD_WHILE_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_i && busy_i) |=> !ld_o); // R8
   AST_CLEAR_STROBE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (clr_h_o && clr_v_o)); // R1
endmodule

// File: rtl/pp_coord_buf.sv
module pp_coord_buf #(
   parameter int HW        = 12,
   parameter int VW        = 12,
   parameter int IW        = 3,
   parameter int HCLR_VLSB = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_h_req_i,
   input  logic          clr_v_req_i,
   input  logic          ld_acc_i,
   input  logic [HW-1:0] hword_i,
   input  logic [VW-1:0] vword_i,
   input  logic [IW-1:0] ilevel_i,
   output logic [HW-1:0] hbuf_o,
   output logic [VW-1:0] vbuf_o,
   output logic [IW-1:0] ilevel_o
);
   localparam logic [IW-1:0] IFLIP = IW'(1) << (IW - 1);

   if (HCLR_VLSB < 0 || HCLR_VLSB > VW) begin : g_bad_split
      $error("HCLR_VLSB must lie within the vertical word");
   end
   if (IW < 1) begin : g_bad_iw
      $error("IW must be at least 1");
   end

   logic [VW-1:0] vclr;
   logic [VW-1:0] vbuf_q;
   logic [HW-1:0] hbuf_q;
   logic [IW-1:0] ibuf_q;

   for (genvar g = 0; g < VW; g++) begin : g_vclr
      if (g < HCLR_VLSB) begin : g_hgrp
         assign vclr[g] = clr_h_req_i;
      end else begin : g_vgrp
         assign vclr[g] = clr_v_req_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hbuf_q <= '0;
         vbuf_q <= '0;
         ibuf_q <= '0;
      end else if (ld_acc_i) begin
         hbuf_q <= hword_i;
         vbuf_q <= vword_i;
         ibuf_q <= ilevel_i ^ IFLIP;
      end else begin
         if (clr_h_req_i) hbuf_q <= '0;
         vbuf_q <= vbuf_q & ~vclr;
         if (clr_v_req_i) ibuf_q <= '0;
      end
   end

   assign hbuf_o   = hbuf_q;
   assign vbuf_o   = vbuf_q;
   assign ilevel_o = ibuf_q ^ IFLIP;

   AST_HGROUP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_h_req_i && !ld_acc_i) |=> (hbuf_o == '0 && vbuf_o[HCLR_VLSB-1:0] == '0)); // R2
   AST_VGROUP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_v_req_i && !ld_acc_i) |=> (vbuf_o[VW-1:HCLR_VLSB] == '0 && ilevel_o == IFLIP)); // R3
   AST_LOAD_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_acc_i |=> (hbuf_o == $past(hword_i) && ilevel_o == $past(ilevel_i))); // R4
endmodule

// File: rtl/pp_phase_timer.sv
module pp_phase_timer
   import pp_pkg::*;
#(
   parameter int SETTLE_CYC  = 35,
   parameter int UNBLANK_CYC = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic settle_o,
   output logic unblank_o,
   output logic done_o,
   output logic busy_o
);
   localparam int MAXC = (SETTLE_CYC > UNBLANK_CYC) ? SETTLE_CYC : UNBLANK_CYC;
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] S_LAST = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] U_LAST = CW'(UNBLANK_CYC - 1);

   if (SETTLE_CYC < 1 || UNBLANK_CYC < 1) begin : g_bad_len
      $error("window lengths must be at least one cycle");
   end

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  ph_q  <= PH_SETTLE;
                  cnt_q <= '0;
               end
            end
            PH_SETTLE: begin
               if (cnt_q == S_LAST) begin
                  ph_q  <= PH_UNBLANK;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_UNBLANK: begin
               if (cnt_q == U_LAST) begin
                  ph_q   <= PH_IDLE;
                  cnt_q  <= '0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               ph_q  <= PH_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign settle_o  = (ph_q == PH_SETTLE);
   assign unblank_o = (ph_q == PH_UNBLANK);
   assign busy_o    = (ph_q != PH_IDLE);
   assign done_o    = done_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settle_o |-> cnt_q <= S_LAST) and (unblank_o |-> cnt_q <= U_LAST)); // R5
   AST_UNBLANK_FOLLOWS_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(unblank_o) |-> $past(settle_o)); // R6
   AST_DONE_FOLLOWS_UNBLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(unblank_o) && !busy_o)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R7
endmodule

// File: rtl/pp_cycle_seq.sv
module pp_cycle_seq #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SETTLE_US   = 35,
   parameter int UNBLANK_US  = 10,
   parameter int SETTLE_CYC  = int'(pp_pkg::us_to_cyc(CLK_HZ, SETTLE_US)),
   parameter int UNBLANK_CYC = int'(pp_pkg::us_to_cyc(CLK_HZ, UNBLANK_US)),
   parameter int HW          = 12,
   parameter int VW          = 12,
   parameter int IW          = 3,
   parameter int HCLR_VLSB   = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          ld_i,
   input  logic [HW-1:0] hword_i,
   input  logic [VW-1:0] vword_i,
   input  logic [IW-1:0] ilevel_i,
   output logic          clr_h_o,
   output logic          clr_v_o,
   output logic          ld_o,
   output logic          settle_o,
   output logic          unblank_o,
   output logic          done_o,
   output logic          busy_o,
   output logic [HW-1:0] hbuf_o,
   output logic [VW-1:0] vbuf_o,
   output logic [IW-1:0] ilevel_o
);
   logic ld_acc;
   logic busy;

   pp_strobe_gen u_strobe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .ld_i     (ld_i),
      .busy_i   (busy),
      .ld_acc_o (ld_acc),
      .clr_h_o  (clr_h_o),
      .clr_v_o  (clr_v_o),
      .ld_o     (ld_o)
   );

   pp_coord_buf #(
      .HW(HW), .VW(VW), .IW(IW), .HCLR_VLSB(HCLR_VLSB)
   ) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_h_req_i (clr_i),
      .clr_v_req_i (clr_i),
      .ld_acc_i    (ld_acc),
      .hword_i     (hword_i),
      .vword_i     (vword_i),
      .ilevel_i    (ilevel_i),
      .hbuf_o      (hbuf_o),
      .vbuf_o      (vbuf_o),
      .ilevel_o    (ilevel_o)
   );

   pp_phase_timer #(
      .SETTLE_CYC(SETTLE_CYC), .UNBLANK_CYC(UNBLANK_CYC)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (ld_acc),
      .settle_o  (settle_o),
      .unblank_o (unblank_o),
      .done_o    (done_o),
      .busy_o    (busy)
   );

   assign busy_o = busy;

   AST_LOAD_STARTS_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_o |-> (settle_o && !unblank_o)); // R5
   AST_WINDOWS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(settle_o && unblank_o)); // R5
endmodule

// File: tb/pp_cycle_seq_tb.sv
module pp_cycle_seq_tb_top;
   localparam int S  = 5;
   localparam int U  = 3;
   localparam int HW = 12;
   localparam int VW = 12;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_i = 1'b0, ld_i = 1'b0;
   logic [HW-1:0] hword = '0;
   logic [VW-1:0] vword = '0;
   logic [IW-1:0] ilev = '0;
   logic clr_h, clr_v, ld_o, settle, unblank, done, busy;
   logic [HW-1:0] hbuf;
   logic [VW-1:0] vbuf;
   logic [IW-1:0] ilev_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pp_cycle_seq #(
      .CLK_HZ(200_000_000), .SETTLE_CYC(S), .UNBLANK_CYC(U),
      .HW(HW), .VW(VW), .IW(IW), .HCLR_VLSB(2)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr_i), .ld_i(ld_i),
      .hword_i(hword), .vword_i(vword), .ilevel_i(ilev),
      .clr_h_o(clr_h), .clr_v_o(clr_v), .ld_o(ld_o), .settle_o(settle),
      .unblank_o(unblank), .done_o(done), .busy_o(busy),
      .hbuf_o(hbuf), .vbuf_o(vbuf), .ilevel_o(ilev_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // One display cycle; ld_at/clr_at are offsets within the cycle (0 = none)
   task automatic run_cycle(input logic [HW-1:0] h, input logic [VW-1:0] v,
                            input logic [IW-1:0] lv, input int ld_at, input int clr_at);
      logic [HW-1:0] eh;
      logic [VW-1:0] ev;
      logic [IW-1:0] el;
      ld_i = 1'b1; hword = h; vword = v; ilev = lv;
      @(negedge clk);
      ld_i = 1'b0;
      eh = h; ev = v; el = lv;
      for (int t = 1; t <= S + U + 1; t++) begin
         chk("R4", "ld_o", int'(ld_o), int'(t == 1));
         chk("R5", "settle_o", int'(settle), int'(t <= S));
         chk("R6", "unblank_o", int'(unblank), int'(t > S && t <= S + U));
         chk("R7", "done_o", int'(done), int'(t == S + U + 1));
         chk("R7", "busy_o", int'(busy), int'(t <= S + U));
         chk("R8", "hbuf_o", int'(hbuf), int'(eh));
         chk("R8", "vbuf_o", int'(vbuf), int'(ev));
         chk("R8", "ilevel_o", int'(ilev_o), int'(el));
         chk("R9", "clr_h_o", int'(clr_h), int'(clr_at != 0 && t == clr_at + 1));
         if (t == ld_at) begin
            ld_i = 1'b1; hword = ~h; vword = ~v; ilev = ~lv;
         end
         if (t == clr_at) begin
            clr_i = 1'b1; eh = '0; ev = '0; el = 3'd4;
         end
         @(negedge clk);
         ld_i = 1'b0; clr_i = 1'b0;
      end
   endtask

   initial begin
      #(200_000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R7", "reset busy_o", int'(busy), 0);
      chk("R7", "reset done_o", int'(done), 0);
      chk("R4", "reset ld_o", int'(ld_o), 0);
      chk("R3", "reset ilevel_o", int'(ilev_o), 4);
      rst_n = 1'b1;
      @(negedge clk);

      // Exhaustive brightness sweep with walking coordinate bits
      for (int i = 0; i < 8; i++) begin
         run_cycle(HW'(12'h001 << i) | 12'h800, VW'(12'hFFF >> i), IW'(i), 0, 0);
      end

      // Standalone clear after a load: both groups, split R1/R2/R3
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      chk("R1", "clr_h_o", int'(clr_h), 1);
      chk("R1", "clr_v_o", int'(clr_v), 1);
      chk("R2", "hbuf_o", int'(hbuf), 0);
      chk("R2", "vbuf_o low bits", int'(vbuf[1:0]), 0);
      chk("R3", "vbuf_o upper bits", int'(vbuf[VW-1:2]), 0);
      chk("R3", "ilevel_o cleared", int'(ilev_o), 4);
      @(negedge clk);
      chk("R1", "clr_h_o single", int'(clr_h), 0);
      chk("R1", "clr_v_o single", int'(clr_v), 0);

      // Loads ignored while busy, at several offsets (R8)
      for (int k = 1; k <= S + U; k += 2) begin
         run_cycle(12'hA5A, 12'h3C3, 3'd6, k, 0);
      end
      // Clears in the middle of a cycle (R9)
      for (int k = 1; k <= S + U; k += 3) begin
         run_cycle(12'h5A5, 12'hC3F, 3'd1, 0, k);
      end
      // Both at once inside a cycle
      run_cycle(12'h777, 12'h123, 3'd2, 4, 4);

      // Simultaneous clear and load while idle: load wins (R10)
      clr_i = 1'b1; ld_i = 1'b1; hword = 12'h9C1; vword = 12'h0F3; ilev = 3'd3;
      @(negedge clk);
      clr_i = 1'b0; ld_i = 1'b0;
      chk("R10", "clr_v_o", int'(clr_v), 1);
      chk("R10", "ld_o", int'(ld_o), 1);
      chk("R10", "hbuf_o", int'(hbuf), 12'h9C1);
      chk("R10", "vbuf_o", int'(vbuf), 12'h0F3);
      chk("R10", "ilevel_o", int'(ilev_o), 3);
      repeat (S + U + 2) @(negedge clk);
      chk("R7", "idle after cycle", int'(busy), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule